// File: doc/BRIEF.md
# PWM emergency output shutdown controller

This block protects a power stage by forcing two groups of PWM lines to a safe level when an external shutdown input fires. Each group has six lines by default. The shutdown input is synchronised and then evaluated under a 3-bit sensing mode. In the edge modes, a qualifying transition latches a disable flag, and the outputs stay blocked until software clears that flag. In the level modes, the outputs stay blocked for as long as the input holds its active level. During that time a shadow of the software-written flag is kept, and it takes over when the level goes away.

Software drives the block through a single-cycle register port. Register 0 holds the mode field, which is guarded by a two-step unlock. Register 1 holds the per-group enables. Register 2 holds the disable flag. A blocked line is driven to a per-bit inactive level that is fixed by parameter. The gating is combinational after the flag and synchroniser registers.

Top module: `pwm_shutdown`

## Requirements
- R1: After reset, register 0 reads 0 (mode 000, not armed), register 1 reads 0, register 2 reads 0, and every PWM output equals its input.
- R2: A write to register 0 with bit 3 set arms the unlock, and register 0 then reads bit 3 as 1. When the very next write goes to register 0 with bit 3 clear, it loads bits [2:0] into the mode field and disarms.
- R3: Any other write between arming and loading disarms without changing the mode. This includes a write to another register, or a second write to register 0 with bit 3 set. A write to register 0 while not armed leaves the mode unchanged.
- R4: Mode 001 senses rising edges, 010 senses falling edges and 011 senses both. A qualifying edge sets the disable flag (register 2 bit 0). A non-qualifying edge leaves it clear.
- R5: In an edge mode the flag stays set after the input returns to idle, and only a write of 0 to register 2 bit 0 clears it.
- R6: Modes 10X sense an active-low level and modes 11X sense an active-high level. While the input holds the active level, register 2 bit 0 reads 1 and the enabled groups are blocked.
- R7: In a level mode, writes to register 2 while the level is active are stored but read back as 1. Once the level clears, both readback and gating follow the stored value.
- R8: In mode 000 the shutdown input has no effect on the flag or the outputs.
- R9: Register 1 bit 0 enables blocking of group A and bit 1 enables blocking of group B. A group whose enable is clear passes its input through, even while the flag is set.
- R10: Each blocked output bit i is driven to bit i of that group's inactive-level parameter.
- R11: After the input changes, an edge-mode block appears on the outputs after the third rising clock edge and a level-mode block after the second.
- R12: When a detected edge and a software write of 0 to the flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shut_i | input | 1 | Asynchronous emergency shutdown input |
| we_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| pwm_a_i | input | N_OUT | Group A PWM lines from the generator |
| pwm_b_i | input | N_OUT | Group B PWM lines from the generator |
| pwm_a_o | output | N_OUT | Group A lines after gating |
| pwm_b_o | output | N_OUT | Group B lines after gating |

## Verification
The bench keeps the default six lines per group and an 8-bit data path. It overrides the inactive levels to 6'b010110 for group A and 6'b101001 for group B. Because these are mixed and differ between the groups, a blocked line cannot be confused with an all-zero default, and a swap of the two groups' idle values would show up. The bench drives each PWM input as the bitwise inverse of its idle value, and later uses a second pattern, so every bit visibly flips when blocking starts.

// File: rtl/pwmk_pkg.sv
package pwmk_pkg;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned KEY_BIT  = 3;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_EN   = 1;
  localparam int unsigned REG_DIS  = 2;
  localparam int unsigned N_GRP    = 2;

  typedef struct packed {
    logic rise;
    logic fall;
    logic lvl;
    logic lvl_hi;
  } sense_t;

  // 000 off, 001 rise, 010 fall, 011 both, 10X level low, 11X level high
  function automatic sense_t decode_mode(input logic [MODE_W-1:0] m);
    sense_t s;
    s = '0;
    if (m[2]) begin
      s.lvl    = 1'b1;
      s.lvl_hi = m[1];
    end else begin
      s.rise = m[0];
      s.fall = m[1];
    end
    return s;
  endfunction
endpackage

// File: rtl/pwmk_sync.sv
module pwmk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pwmk_detect.sv
module pwmk_detect
  import pwmk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              edge_o,
  output logic              lvl_o
);
  sense_t sen;
  logic   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;
  end

  assign sen    = decode_mode(mode_i);
  assign edge_o = (sen.rise & s_i & ~prev_q) | (sen.fall & ~s_i & prev_q);
  assign lvl_o  = sen.lvl & (s_i == sen.lvl_hi);

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == '0) |-> !(edge_o || lvl_o)); // R8
endmodule

// File: rtl/pwmk_regs.sv
module pwmk_regs
  import pwmk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              edge_i,
  input  logic              lvl_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [N_GRP-1:0]  en_o,
  output logic              eff_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(REG_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(REG_DIS);

  logic [MODE_W-1:0] mode_q;
  logic [N_GRP-1:0]  en_q;
  logic              arm_q;
  logic              dis_q;
  logic              wr_ctrl, wr_en, wr_dis;
  logic              unused_wdata;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_en   = we_i && (addr_i == A_EN);
  assign wr_dis  = we_i && (addr_i == A_DIS);
  assign unused_wdata = ^wdata_i[DATA_W-1:KEY_BIT+1];

  // unlock: arm, then the very next write must be ctrl with key clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      arm_q  <= 1'b0;
    end else if (we_i) begin
      if (arm_q) begin
        arm_q <= 1'b0;
        if (wr_ctrl && !wdata_i[KEY_BIT]) mode_q <= wdata_i[MODE_W-1:0];
      end else if (wr_ctrl && wdata_i[KEY_BIT]) begin
        arm_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= wdata_i[N_GRP-1:0];
  end

  // stored flag doubles as level-mode shadow; detected edge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dis_q <= 1'b0;
    else if (edge_i) dis_q <= 1'b1;
    else if (wr_dis) dis_q <= wdata_i[0];
  end

  assign eff_o  = dis_q | lvl_i;
  assign mode_o = mode_q;
  assign en_o   = en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = DATA_W'({arm_q, mode_q});
      A_EN:    rdata_o = DATA_W'(en_q);
      A_DIS:   rdata_o = DATA_W'(eff_o);
      default: rdata_o = '0;
    endcase
  end

  AST_MODE_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(arm_q && we_i)); // R3
  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> dis_q); // R12
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q && !wr_dis) |=> dis_q); // R5
  AST_LVL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && addr_i == A_DIS) |-> rdata_o[0]); // R6
endmodule

// File: rtl/pwmk_gate.sv
module pwmk_gate #(
  parameter int unsigned  N_OUT = 6,
  parameter logic [N_OUT-1:0] IDLE = '0
) (
  input  logic             block_i,
  input  logic [N_OUT-1:0] d_i,
  output logic [N_OUT-1:0] q_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_bit
    assign q_o[g] = block_i ? IDLE[g] : d_i[g];
  end
endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown
  import pwmk_pkg::*;
#(
  parameter int unsigned N_OUT  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter logic [N_OUT-1:0] IDLE_A = '0,
  parameter logic [N_OUT-1:0] IDLE_B = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shut_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_OUT-1:0]  pwm_a_i,
  input  logic [N_OUT-1:0]  pwm_b_i,
  output logic [N_OUT-1:0]  pwm_a_o,
  output logic [N_OUT-1:0]  pwm_b_o
);
  logic              shut_s;
  logic              edge_hit, lvl_act, eff;
  logic [MODE_W-1:0] mode;
  logic [N_GRP-1:0]  en;

  pwmk_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(shut_i), .q_o(shut_s)
  );

  pwmk_detect u_det (
    .clk_i, .rst_ni, .s_i(shut_s), .mode_i(mode), .edge_o(edge_hit), .lvl_o(lvl_act)
  );

  pwmk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .edge_i(edge_hit), .lvl_i(lvl_act),
    .mode_o(mode), .en_o(en), .eff_o(eff), .rdata_o
  );

  pwmk_gate #(.N_OUT(N_OUT), .IDLE(IDLE_A)) u_gate_a (
    .block_i(eff & en[0]), .d_i(pwm_a_i), .q_o(pwm_a_o)
  );

  pwmk_gate #(.N_OUT(N_OUT), .IDLE(IDLE_B)) u_gate_b (
    .block_i(eff & en[1]), .d_i(pwm_b_i), .q_o(pwm_b_o)
  );

  AST_BLOCK_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_act && en[0]) |-> (pwm_a_o == IDLE_A)); // R10
  AST_PASS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[1] |-> (pwm_b_o == pwm_b_i)); // R9
endmodule

// File: tb/sim_pwm_shutdown.sv
module sim_pwm_shutdown;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] IA = 6'b010110;
  localparam logic [5:0] IB = 6'b101001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shut = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pa_i = ~IA, pb_i = ~IB;
  logic [5:0] pa_o, pb_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shutdown #(.N_OUT(6), .DATA_W(8), .ADDR_W(2), .IDLE_A(IA), .IDLE_B(IB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .shut_i(shut), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_a_i(pa_i), .pwm_b_i(pb_i),
    .pwm_a_o(pa_o), .pwm_b_o(pb_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic out_chk(input string tag, input bit blk_a, input bit blk_b);
    #1;
    chk({tag, " grpA"}, pa_o, blk_a ? IA : pa_i);
    chk({tag, " grpB"}, pb_o, blk_b ? IB : pb_i);
  endtask

  task automatic set_mode(input logic [2:0] m);
    wr(2'd0, 8'h08);
    wr(2'd0, {5'b0, m});
  endtask

  task automatic drive_in(input logic v, input int cyc);
    @(negedge clk); shut = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 2'd0, 8'h00);
    rd_chk("R1 en", 2'd1, 8'h00);
    rd_chk("R1 dis", 2'd2, 8'h00);
    out_chk("R1 pass", 0, 0);
  endtask

  task automatic t_unlock;
    wr(2'd0, 8'h0B);
    rd_chk("R2 armed", 2'd0, 8'h08);
    wr(2'd0, 8'h02);
    rd_chk("R2 loaded", 2'd0, 8'h02);
    set_mode(3'd0);
    rd_chk("R2 back to off", 2'd0, 8'h00);
  endtask

  task automatic t_cancel;
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    rd_chk("R3 other reg cancels", 2'd0, 8'h00);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h08);
    rd_chk("R3 re-key cancels", 2'd0, 8'h00);
    wr(2'd0, 8'h01);
    rd_chk("R3 unarmed ignored", 2'd0, 8'h00);
  endtask

  task automatic t_off;
    wr(2'd1, 8'h03);
    drive_in(1'b1, 4);
    rd_chk("R8 high no flag", 2'd2, 8'h00);
    out_chk("R8 high pass", 0, 0);
    drive_in(1'b0, 4);
    rd_chk("R8 low no flag", 2'd2, 8'h00);
    out_chk("R8 low pass", 0, 0);
  endtask

  task automatic t_rise;
    set_mode(3'd1);
    @(negedge clk); shut = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    out_chk("R11 edge not yet", 0, 0);
    @(negedge clk);
    out_chk("R11 R10 edge blocked", 1, 1);
    rd_chk("R4 rise sets", 2'd2, 8'h01);
    drive_in(1'b0, 4);
    rd_chk("R5 flag held", 2'd2, 8'h01);
    out_chk("R5 still blocked", 1, 1);
    wr(2'd2, 8'h00);
    rd_chk("R5 cleared", 2'd2, 8'h00);
    out_chk("R5 pass again", 0, 0);
    drive_in(1'b1, 4);
    wr(2'd2, 8'h00);
    drive_in(1'b0, 4);
    rd_chk("R4 fall ignored in rise", 2'd2, 8'h00);
  endtask

  task automatic t_fall;
    set_mode(3'd2);
    drive_in(1'b1, 4);
    rd_chk("R4 rise ignored in fall", 2'd2, 8'h00);
    drive_in(1'b0, 4);
    rd_chk("R4 fall sets", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_both;
    set_mode(3'd3);
    drive_in(1'b1, 4);
    rd_chk("R4 both rise", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
    drive_in(1'b0, 4);
    rd_chk("R4 both fall", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
    rd_chk("R4 both cleared", 2'd2, 8'h00);
  endtask

  task automatic t_prio;
    @(negedge clk); shut = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd2; wdata = 8'h00;
    @(negedge clk); we = 1'b0;
    rd_chk("R12 edge beats clear", 2'd2, 8'h01);
    drive_in(1'b0, 4);
    wr(2'd2, 8'h00);
    rd_chk("R12 cleared after", 2'd2, 8'h00);
  endtask

  task automatic t_level_hi;
    set_mode(3'd6);
    @(negedge clk); shut = 1'b1;
    @(posedge clk); @(negedge clk);
    out_chk("R11 level not yet", 0, 0);
    @(negedge clk);
    out_chk("R11 R6 level blocked", 1, 1);
    rd_chk("R6 reads 1", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
    rd_chk("R7 shadow write hidden", 2'd2, 8'h01);
    drive_in(1'b0, 4);
    rd_chk("R7 stored 0 shows", 2'd2, 8'h00);
    out_chk("R7 pass", 0, 0);
    drive_in(1'b1, 4);
    wr(2'd2, 8'h01);
    drive_in(1'b0, 4);
    rd_chk("R7 stored 1 shows", 2'd2, 8'h01);
    out_chk("R7 stored 1 blocks", 1, 1);
    wr(2'd2, 8'h00);
    rd_chk("R7 cleared", 2'd2, 8'h00);
  endtask

  task automatic t_level_lo;
    set_mode(3'd4);
    repeat (3) @(negedge clk);
    rd_chk("R6 low active", 2'd2, 8'h01);
    out_chk("R6 low blocked", 1, 1);
    drive_in(1'b1, 4);
    rd_chk("R6 low released", 2'd2, 8'h00);
    set_mode(3'd5);
    out_chk("R6 101 idle pass", 0, 0);
    drive_in(1'b0, 4);
    out_chk("R6 101 blocked", 1, 1);
    drive_in(1'b1, 4);
  endtask

  task automatic t_enables;
    set_mode(3'd1);
    drive_in(1'b0, 4);
    wr(2'd1, 8'h01);
    pa_i = 6'b100101; pb_i = 6'b001110;
    drive_in(1'b1, 4);
    out_chk("R9 only A", 1, 0);
    wr(2'd2, 8'h00);
    drive_in(1'b0, 2);
    wr(2'd1, 8'h02);
    rd_chk("R9 en readback", 2'd1, 8'h02);
    drive_in(1'b1, 4);
    out_chk("R9 R10 only B", 0, 1);
    wr(2'd1, 8'h00);
    rd_chk("R9 flag still set", 2'd2, 8'h01);
    out_chk("R9 none enabled", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_cancel();
    t_off();
    t_rise();
    t_fall();
    t_both();
    t_prio();
    t_level_hi();
    t_level_lo();
    t_enables();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule